// File: doc/BRIEF.md
# Blitter Command Register Front End

This block is the host-facing register set of a 2D drawing engine. A simple write/read strobe with per-byte enables reaches a small set of word-aligned registers: the engine control word, source and destination coordinates, the width/height pair, two colours, and a raster-op byte with a byte mask next to it. The block turns a launch request into a one-clock start pulse. Along with that pulse it presents a snapshot of the control word and the three geometry registers to the engine core.

A launch comes from one of two places. The first is a control-word write with its top bit set. The second is a write to a coordinate register that a two-bit quick-start field in the control word has armed. With quick start, the host can fire a prepared operation by writing only the new position or size. If the engine reports busy, or a command is already waiting, the snapshot goes into a small command queue. Queued commands launch in order once the engine is idle. A status word reports the number of free queue slots and the busy flags.

Top module: `blt_cmd_front`

## Requirements
- R1: After reset all registers read zero, no start pulse is issued, and the status word reports FIFO_DEPTH (4) free slots.
- R2: A write changes only the byte lanes whose enable is set (be[0] = bits 7:0 … be[3] = bits 31:24). The colour registers sit at 0x60 (foreground) and 0x64 (background).
- R3: A control write (0x40) with bit 31 set launches the operation. When idle, start_pulse is high in the cycle after the write and go_ctrl shows the written word. Bit 31 is never stored, so it reads back 0. Bits 3:0 carry the operation code.
- R4: The quick-start field is control bits 30:29. Code 0 arms nothing. Code 1 fires on a write to width (0x58) with be[0] or be[1] set. Code 2 fires on any lane written at source XY (0x50). Code 3 fires on any lane written at destination XY (0x54). A height-only write (0x58 lanes 3:2) does not fire.
- R5: start_pulse is exactly one clock wide, and two pulses are never adjacent.
- R6: A launch requested while eng_busy is high, or while the queue holds commands, is queued. Queued commands are issued oldest first, and only while eng_busy is low.
- R7: The status word at 0x1FC has the free-slot count in bits 3:0, hostblt_busy in bit 8, eng_busy in bit 10, and zeros elsewhere.
- R8: A launch requested while the queue is full is discarded.
- R9: The raster-op byte is read at 0x46 (bits 23:16 of word 0x44) and the byte mask at 0x47 (bits 31:24). The low half of that word and every unmapped offset read zero. Read data appears the cycle after rd_en.
- R10: The go_* outputs carry the register values as they stood when the launch was requested. Later register writes do not change a queued command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (9) | Byte address of the accessed 32-bit word |
| be | input | 4 | Byte-lane enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| eng_busy | input | 1 | Engine core busy |
| hostblt_busy | input | 1 | Host-transfer busy, reported in status |
| start_pulse | output | 1 | One-clock launch strobe |
| go_ctrl | output | 32 | Launched control word |
| go_src | output | 32 | Launched source XY (Y in 31:16) |
| go_dst | output | 32 | Launched destination XY |
| go_dim | output | 32 | Launched width (15:0) / height (31:16) |
| fg_color | output | 32 | Foreground colour |
| bg_color | output | 32 | Background colour |
| rop | output | 8 | Raster-op code |
| byte_mask | output | 8 | Byte mask |

## Verification
The bench sweeps every quick-start code against each coordinate register and three lane patterns. This catches a trigger decoder that fires on the wrong register, fires on a height-only write, or ignores partial writes. All sixteen byte-enable patterns are replayed on a colour register to expose lane swaps. The queue is filled past capacity while the engine is busy: a design that overwrote on full, launched while busy, reordered commands or snapshotted late would show extra pulses, wrong opcodes or the wrong source coordinates once busy drops. Reading control bit 31 back, and reading the status bits, catches a start bit that sticks and a mis-placed free count.

// File: rtl/blt_pkg.sv
package blt_pkg;
   localparam int NSLOT  = 7;
   localparam int S_CTRL = 0;
   localparam int S_RMSK = 1;
   localparam int S_SRC  = 2;
   localparam int S_DST  = 3;
   localparam int S_DIM  = 4;
   localparam int S_FG   = 5;
   localparam int S_BG   = 6;

   localparam int GO_BIT = 31;
   localparam int QS_LSB = 29;
   localparam logic [6:0] STATUS_WORD = 7'h7F;  // byte offset 0x1FC

   typedef enum logic [1:0] {QS_NONE = 2'd0, QS_DIM = 2'd1, QS_SRC = 2'd2, QS_DST = 2'd3} qs_e;

   typedef struct packed {
      logic [31:0] ctrl;
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] dim;
   } blt_cmd_t;

   // word address (byte offset / 4) of each register slot
   function automatic logic [6:0] slot_word(input int i);
      case (i)
         S_CTRL:  return 7'h10;
         S_RMSK:  return 7'h11;
         S_SRC:   return 7'h14;
         S_DST:   return 7'h15;
         S_DIM:   return 7'h16;
         S_FG:    return 7'h18;
         default: return 7'h19;
      endcase
   endfunction

   // writable lanes of each slot
   function automatic logic [3:0] slot_lanes(input int i);
      return (i == S_RMSK) ? 4'b1100 : 4'b1111;
   endfunction
endpackage

// File: rtl/blt_regfile.sv
module blt_regfile
   import blt_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [3:0]                   be,
   input  logic [31:0]                  wdata,
   output logic [NSLOT-1:0]             slot_hit,
   output logic [NSLOT-1:0][31:0]       slot_cur,
   output logic [NSLOT-1:0][31:0]       slot_nxt
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [3:0]  lanes;
      logic [31:0] q;
      logic [31:0] merged;

      assign lanes       = be & slot_lanes(g);
      assign slot_hit[g] = wr_en && (word == WORD_W'(slot_word(g)));

      always_comb begin
         merged = q;
         for (int b = 0; b < 4; b++)
            if (lanes[b]) merged[8*b +: 8] = wdata[8*b +: 8];
         if (g == S_CTRL) merged[GO_BIT] = 1'b0;
      end

      assign slot_nxt[g] = slot_hit[g] ? merged : q;
      assign slot_cur[g] = q;

      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= slot_nxt[g];
      end
   end
endmodule

// File: rtl/blt_trigger.sv
module blt_trigger
   import blt_pkg::*;
#(
   parameter bit QUICK_EN = 1'b1
) (
   input  logic [NSLOT-1:0] slot_hit,
   input  logic [3:0]       be,
   input  logic             wdata_go,
   input  logic [1:0]       qs_code,
   output logic             launch_req
);
   logic explicit_go;
   logic armed_hit;

   assign explicit_go = slot_hit[S_CTRL] && be[3] && wdata_go;

   if (QUICK_EN) begin : g_quick
      always_comb begin
         case (qs_e'(qs_code))
            QS_DIM:  armed_hit = slot_hit[S_DIM] && (|be[1:0]);
            QS_SRC:  armed_hit = slot_hit[S_SRC] && (|be);
            QS_DST:  armed_hit = slot_hit[S_DST] && (|be);
            default: armed_hit = 1'b0;
         endcase
      end
   end else begin : g_noquick
      assign armed_hit = 1'b0;
   end

   assign launch_req = explicit_go || armed_hit;
endmodule

// File: rtl/blt_cmd_fifo.sv
module blt_cmd_fifo #(
   parameter int W     = 128,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty,
   output logic                         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_inc, rp_inc;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   if (POW2) begin : g_wrap_nat
      assign wp_inc = wp + 1'b1;
      assign rp_inc = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_inc = (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
      assign rp_inc = (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_inc;
         if (do_pop)  rp <= rp_inc;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk)
      if (do_push) mem[wp] <= din;

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);  // R8
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);  // R6
endmodule

// File: rtl/blt_cmd_front.sv
module blt_cmd_front
   import blt_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int FIFO_DEPTH = 4,
   parameter bit QUICK_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              eng_busy,
   input  logic              hostblt_busy,
   output logic              start_pulse,
   output logic [31:0]       go_ctrl,
   output logic [31:0]       go_src,
   output logic [31:0]       go_dst,
   output logic [31:0]       go_dim,
   output logic [31:0]       fg_color,
   output logic [31:0]       bg_color,
   output logic [7:0]        rop,
   output logic [7:0]        byte_mask
);
   localparam int WORD_W = ADDR_W - 2;
   localparam int FREE_W = $clog2(FIFO_DEPTH+1);
   localparam int CMD_W  = $bits(blt_cmd_t);

   if (FIFO_DEPTH < 1 || FIFO_DEPTH > 15) begin : g_bad_depth
      $error("FIFO_DEPTH must lie in 1..15 to fit the status field");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must be at least 9");
   end

   logic [NSLOT-1:0]       slot_hit;
   logic [NSLOT-1:0][31:0] slot_cur, slot_nxt;
   logic                   launch_req;
   blt_cmd_t               snap, head;
   logic [FREE_W-1:0]      fifo_cnt;
   logic                   fifo_empty, fifo_full;
   logic                   can_go, direct, pop, push;

   blt_regfile #(.ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
      .slot_hit(slot_hit), .slot_cur(slot_cur), .slot_nxt(slot_nxt)
   );

   blt_trigger #(.QUICK_EN(QUICK_EN)) i_trig (
      .slot_hit(slot_hit), .be(be), .wdata_go(wdata[GO_BIT]),
      .qs_code(slot_cur[S_CTRL][QS_LSB +: 2]), .launch_req(launch_req)
   );

   assign snap = '{ctrl: slot_nxt[S_CTRL], src: slot_nxt[S_SRC],
                   dst:  slot_nxt[S_DST],  dim: slot_nxt[S_DIM]};

   assign can_go = !eng_busy && !start_pulse;
   assign direct = launch_req && fifo_empty && can_go;
   assign pop    = !fifo_empty && can_go;
   assign push   = launch_req && !direct && !fifo_full;

   blt_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(snap), .dout(head),
      .count(fifo_cnt), .empty(fifo_empty), .full(fifo_full)
   );

   blt_cmd_t go_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         go_q        <= '0;
      end else begin
         start_pulse <= direct || pop;
         if (direct)   go_q <= snap;
         else if (pop) go_q <= head;
      end
   end

   assign go_ctrl = go_q.ctrl;
   assign go_src  = go_q.src;
   assign go_dst  = go_q.dst;
   assign go_dim  = go_q.dim;

   assign fg_color  = slot_cur[S_FG];
   assign bg_color  = slot_cur[S_BG];
   assign rop       = slot_cur[S_RMSK][23:16];
   assign byte_mask = slot_cur[S_RMSK][31:24];

   // read path
   logic [WORD_W-1:0] word;
   logic [31:0]       rd_val;
   logic              rd_mapped;
   logic [FREE_W-1:0] free_slots;

   assign word       = addr[ADDR_W-1:2];
   assign free_slots = FREE_W'(FIFO_DEPTH) - fifo_cnt;

   always_comb begin
      rd_val    = '0;
      rd_mapped = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         if (word == WORD_W'(slot_word(i))) begin
            rd_val    = slot_cur[i];
            rd_mapped = 1'b1;
         end
      end
      if (word == WORD_W'(STATUS_WORD)) begin
         rd_val        = '0;
         rd_val[3:0]   = 4'(free_slots);
         rd_val[8]     = hostblt_busy;
         rd_val[10]    = eng_busy;
         rd_mapped     = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
      else            rdata <= '0;
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);  // R5
   AST_IDLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(!eng_busy));  // R6
   AST_QS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_req && fifo_empty && !eng_busy && !start_pulse) |=> start_pulse);  // R4
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_mapped) |=> (rdata == '0));  // R9
endmodule

// File: tb/test_blt_cmd_front.sv
module test_blt_cmd_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [8:0]  addr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        eng_busy = 1'b0, hostblt_busy = 1'b0;
   logic        start_pulse;
   logic [31:0] go_ctrl, go_src, go_dst, go_dim, fg_color, bg_color;
   logic [7:0]  rop, byte_mask;

   int tests = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   blt_cmd_front i_blt_cmd_front (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
      .wdata(wdata), .rdata(rdata), .eng_busy(eng_busy), .hostblt_busy(hostblt_busy),
      .start_pulse(start_pulse), .go_ctrl(go_ctrl), .go_src(go_src), .go_dst(go_dst),
      .go_dim(go_dim), .fg_color(fg_color), .bg_color(bg_color), .rop(rop),
      .byte_mask(byte_mask)
   );

   // pulse monitor
   int          n_pulse = 0, n_adjacent = 0;
   logic        prev_pulse = 1'b0;
   logic [31:0] log_ctrl [64];
   logic [31:0] log_src  [64];
   always @(negedge clk) begin
      if (start_pulse) begin
         log_ctrl[n_pulse % 64] = go_ctrl;
         log_src[n_pulse % 64]  = go_src;
         n_pulse = n_pulse + 1;
         if (prev_pulse) n_adjacent = n_adjacent + 1;
      end
      prev_pulse = start_pulse;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [3:0] b, input logic [31:0] d);
      wr_en = 1'b1; addr = a; be = b; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; be = '0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, lm, pat;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(9'h1FC, d); chk("R1 status", d, 32'h4);
      rd(9'h040, d); chk("R1 ctrl", d, 32'h0);
      rd(9'h050, d); chk("R1 src", d, 32'h0);
      chk("R1 pulse", {31'b0, start_pulse}, 32'h0);

      // R2 byte-lane sweep on foreground colour
      pat = 32'hA5C3_5A3C;
      for (int b = 0; b < 16; b++) begin
         wr(9'h060, 4'hF, 32'h0);
         wr(9'h060, 4'(b), pat);
         lm = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
         rd(9'h060, d);
         chk($sformatf("R2 be=%0d", b), d, pat & lm);
      end
      wr(9'h064, 4'hF, 32'h1234_5678);
      chk("R2 bg port", bg_color, 32'h1234_5678);

      // R9 raster-op / mask and unmapped reads
      wr(9'h044, 4'hF, 32'hDDCC_BBAA);
      rd(9'h044, d); chk("R9 rop/mask word", d, 32'hDDCC_0000);
      chk("R9 rop port", {24'b0, rop}, 32'hCC);
      chk("R9 mask port", {24'b0, byte_mask}, 32'hDD);
      rd(9'h048, d); chk("R9 unmapped 0x48", d, 32'h0);
      rd(9'h05C, d); chk("R9 unmapped 0x5C", d, 32'h0);
      rd(9'h100, d); chk("R9 unmapped 0x100", d, 32'h0);

      // R3 explicit start
      wr(9'h050, 4'hF, 32'h0002_0001);
      wr(9'h054, 4'hF, 32'h0004_0003);
      wr(9'h058, 4'hF, 32'h0010_0020);
      base = n_pulse;
      wr(9'h040, 4'hF, 32'h8000_0001);
      chk("R3 pulse after write", {31'b0, start_pulse}, 32'h1);
      chk("R3 go_ctrl", go_ctrl, 32'h0000_0001);
      chk("R10 go_src", go_src, 32'h0002_0001);
      chk("R10 go_dim", go_dim, 32'h0010_0020);
      idle(3);
      chk("R5 one pulse", n_pulse - base, 1);
      rd(9'h040, d); chk("R3 start bit not stored", d, 32'h0000_0001);

      // R4 quick-start sweep
      for (int code = 0; code < 4; code++) begin
         for (int t = 0; t < 3; t++) begin
            for (int p = 0; p < 3; p++) begin
               logic [8:0] ta;
               logic [3:0] tb;
               int expn;
               ta = (t == 0) ? 9'h050 : (t == 1) ? 9'h054 : 9'h058;
               tb = (p == 0) ? 4'b0011 : (p == 1) ? 4'b1100 : 4'b1111;
               expn = ((code == 2 && t == 0) || (code == 3 && t == 1) ||
                       (code == 1 && t == 2 && tb[1:0] != 0)) ? 1 : 0;
               wr(9'h040, 4'hF, {1'b0, 2'(code), 25'b0, 4'h2});
               idle(2);
               base = n_pulse;
               wr(ta, tb, 32'h0BAD_0000 | 32'(code*16 + t*4 + p));
               idle(3);
               chk($sformatf("R4 code=%0d reg=%0d be=%b", code, t, tb), n_pulse - base, expn);
               if (expn == 1)
                  chk("R4 launched code", {30'b0, log_ctrl[base % 64][30:29]}, 32'(code));
            end
         end
      end

      // R6/R7/R8/R10 queue while busy
      wr(9'h040, 4'hF, 32'h0);
      idle(2);
      eng_busy = 1'b1; hostblt_busy = 1'b1;
      base = n_pulse;
      for (int k = 0; k < 5; k++) begin
         wr(9'h050, 4'hF, 32'h100 + 32'(k));
         wr(9'h040, 4'hF, 32'h8000_0000 | 32'(k + 1));
         if (k == 2) begin
            rd(9'h1FC, d); chk("R7 status three queued", d, 32'h0000_0501);
         end
      end
      rd(9'h1FC, d); chk("R8 status full", d, 32'h0000_0500);
      wr(9'h050, 4'hF, 32'hFFFF_FFFF);
      idle(4);
      chk("R6 no launch while busy", n_pulse - base, 0);
      eng_busy = 1'b0; hostblt_busy = 1'b0;
      idle(14);
      chk("R8 only four launched", n_pulse - base, 4);
      for (int k = 0; k < 4; k++) begin
         chk($sformatf("R6 order %0d", k), log_ctrl[(base + k) % 64], 32'(k + 1));
         chk($sformatf("R10 snapshot src %0d", k), log_src[(base + k) % 64], 32'h100 + 32'(k));
      end
      rd(9'h1FC, d); chk("R7 status drained", d, 32'h4);
      chk("R5 no adjacent pulses", n_adjacent, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule